// File: doc/BRIEF.md
# Bus Error Cause Status Register

This block keeps a record of why the processor's most recent bus transfers were ended by a transfer error acknowledge. Each time the error strobe pulses, a 2-bit cause code is sampled. The code selects one of three sticky flags: local bus time-out, DRAM parity error, or error with no further cause given. Once a flag is set, it holds until software clears all three at once by writing a one to a single command bit.

Software sees the block as one 8-bit register that fills the upper byte, bits 15 to 8, of a 16-bit word. Bit 8 of the word is carried on data line 0 of the port. The three flag values are also driven on a separate output. A second copy of the same status held elsewhere in the chip can follow that output and stay in step. A parameter marks parity as unsupported. When it does, the parity flag is not built and reads as zero.

Top module: `berr_cause_reg`

## Requirements
- R1: When either the power-up reset or the local reset is asserted, all flags clear. After reset, `rd_data` reads 0x00.
- R2: A strobe with cause code 01 (time-out) sets word bit 8, which is `rd_data[0]`. The bit is visible in the cycle after the strobe edge.
- R3: With `PARITY_EN`=1, a strobe with cause code 10 (parity) sets word bit 9, which is `rd_data[1]`.
- R4: A strobe with cause code 11 (no extra status) sets word bit 10, which is `rd_data[2]`.
- R5: Cause code 00 with the strobe high leaves every flag unchanged. So does any cause code while the strobe is low.
- R6: Flags are sticky. A set flag stays set through later events of other causes and through writes that do not clear.
- R7: A write with word bit 11 (`wr_data[3]`) at one clears all three flags. A write with that bit at zero has no effect. The other written bits are ignored.
- R8: Word bit 11 and word bits 15..12 (`rd_data[7:3]`) always read zero.
- R9: If an error event and a clear write fall in the same cycle, the flag for the event's cause ends up set and the other flags end up cleared.
- R10: With `PARITY_EN`=0, word bit 9 reads zero, even after a parity-cause event.
- R11: `flag_mirror[2:0]` always equals `rd_data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| lrst_n | input | 1 | Local reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data for word bits 15..8 |
| rd_data | output | 8 | Read data for word bits 15..8 |
| err_stb | input | 1 | Transfer error acknowledge strobe |
| err_cause | input | 2 | Cause code, sampled while `err_stb` is high |
| flag_mirror | output | 3 | Flag values {no-status, parity, time-out} for a duplicate copy |

## Verification
Two things can land in the same cycle: an error event that sets a flag, and a clear command written by software. To provoke this, the bench first sets several flags. It then drives a strobe with one cause together with a write that has bit 11 set, all in a single cycle. On the following cycle the bench reads back and expects exactly the event's flag set and the earlier flags gone. It repeats this for each cause code, and also for the parity cause on the instance built without parity.

// File: rtl/berr_cause_pkg.sv
package berr_cause_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned CAUSE_W = 2;
   localparam int unsigned N_FLAG  = 3;
   localparam int unsigned CLR_BIT = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_TMO    = 2'b01,
      CAUSE_PAR    = 2'b10,
      CAUSE_NOSTAT = 2'b11
   } cause_e;

   localparam int unsigned IDX_TMO    = 0;
   localparam int unsigned IDX_PAR    = 1;
   localparam int unsigned IDX_NOSTAT = 2;
endpackage

// File: rtl/berr_cause_decode.sv
module berr_cause_decode
   import berr_cause_pkg::*;
#(
   parameter int unsigned NF = N_FLAG
) (
   input  logic               stb_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [NF-1:0]      set_o
);
   generate
      if (NF != 3) begin : g_bad_nf
         $error("berr_cause_decode: NF must be 3");
      end
      for (genvar g = 0; g < NF; g++) begin : g_dec
         localparam logic [CAUSE_W-1:0] CODE = CAUSE_W'(g + 1);
         assign set_o[g] = stb_i && (cause_i == CODE);
      end
   endgenerate
endmodule

// File: rtl/berr_flag_cell.sv
module berr_flag_cell #(
   parameter bit IMPL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (IMPL) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i | (q & ~clr_i);
         end
         assign q_o = q;

         p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
         p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !q_o);
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o && !clr_i) |=> q_o);
         p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_o && !set_i) |=> !q_o);
      end else begin : g_tied
         assign q_o = 1'b0;
         logic unused_in;
         assign unused_in = set_i ^ clr_i ^ clk ^ rst_n;
      end
   endgenerate
endmodule

// File: rtl/berr_cause_reg.sv
module berr_cause_reg
   import berr_cause_pkg::*;
#(
   parameter bit PARITY_EN = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               lrst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   input  logic               err_stb,
   input  logic [CAUSE_W-1:0] err_cause,
   output logic [N_FLAG-1:0]  flag_mirror
);
   localparam int unsigned RSV_W = REG_W - CLR_BIT;

   logic              rst_n;
   logic              clr_cmd;
   logic [N_FLAG-1:0] set_vec;
   logic [N_FLAG-1:0] flags;

   assign rst_n   = por_n & lrst_n;
   assign clr_cmd = wr_en & wr_data[CLR_BIT];

   berr_cause_decode #(.NF(N_FLAG)) u_dec (
      .stb_i  (err_stb),
      .cause_i(err_cause),
      .set_o  (set_vec)
   );

   generate
      if (CLR_BIT != N_FLAG) begin : g_bad_layout
         $error("berr_cause_reg: clear bit must sit just above the flags");
      end
      for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
         localparam bit IMPL = (g == IDX_PAR) ? PARITY_EN : 1'b1;
         berr_flag_cell #(.IMPL(IMPL)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_vec[g]),
            .clr_i(clr_cmd),
            .q_o  (flags[g])
         );
      end
   endgenerate

   assign rd_data     = {{RSV_W{1'b0}}, flags};
   assign flag_mirror = flags;

   logic unused_wr;
   assign unused_wr = ^{wr_data[REG_W-1:CLR_BIT+1], wr_data[CLR_BIT-1:0]};

   p_tmo_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_stb && err_cause == CAUSE_TMO) |=> rd_data[IDX_TMO]);
   p_nostat_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_stb && err_cause == CAUSE_NOSTAT) |=> rd_data[IDX_NOSTAT]);
endmodule

// File: tb/sim_berr_cause_reg.sv
module sim_berr_cause_reg;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, lrst_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       err_stb = 1'b0;
   logic [1:0] err_cause = 2'b00;
   logic [7:0] rd0, rd1;
   logic [2:0] mir0, mir1;
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   berr_cause_reg #(.PARITY_EN(1'b1)) u0 (
      .clk(clk), .por_n(por_n), .lrst_n(lrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd0), .err_stb(err_stb), .err_cause(err_cause), .flag_mirror(mir0));
   berr_cause_reg #(.PARITY_EN(1'b0)) u1 (
      .clk(clk), .por_n(por_n), .lrst_n(lrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd1), .err_stb(err_stb), .err_cause(err_cause), .flag_mirror(mir1));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
      if (mir0 !== rd0[2:0]) begin
         n_bad++;
         $display("FAIL R11 mirror u0: actual %0h expected %0h", mir0, rd0[2:0]);
      end
      if (mir1 !== rd1[2:0]) begin
         n_bad++;
         $display("FAIL R11 mirror u1: actual %0h expected %0h", mir1, rd1[2:0]);
      end
   endtask

   // one cycle of stimulus, driven at negedge, settled at the next negedge
   task automatic cyc(input logic stb, input logic [1:0] c, input logic we, input logic [7:0] d);
      @(negedge clk);
      err_stb = stb; err_cause = c; wr_en = we; wr_data = d;
      @(negedge clk);
      err_stb = 1'b0; err_cause = 2'b00; wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset;
      chk("R1 por u0", rd0, 8'h00);
      cyc(1'b1, 2'b01, 1'b0, 8'h00);
      cyc(1'b1, 2'b11, 1'b0, 8'h00);
      @(negedge clk); lrst_n = 1'b0;
      @(negedge clk); chk("R1 local reset u0", rd0, 8'h00);
      chk("R1 local reset u1", rd1, 8'h00);
      lrst_n = 1'b1;
   endtask

   task automatic t_causes;
      cyc(1'b1, 2'b01, 1'b0, 8'h00); chk("R2 timeout", rd0, 8'h01);
      cyc(1'b0, 2'b00, 1'b1, 8'h08);
      cyc(1'b1, 2'b10, 1'b0, 8'h00); chk("R3 parity", rd0, 8'h02);
      chk("R10 parity off", rd1, 8'h00);
      cyc(1'b0, 2'b00, 1'b1, 8'h08);
      cyc(1'b1, 2'b11, 1'b0, 8'h00); chk("R4 nostat", rd0, 8'h04);
      cyc(1'b0, 2'b00, 1'b1, 8'h08); chk("R7 clear", rd0, 8'h00);
   endtask

   task automatic t_ignored;
      cyc(1'b1, 2'b00, 1'b0, 8'h00); chk("R5 code none", rd0, 8'h00);
      cyc(1'b0, 2'b01, 1'b0, 8'h00); chk("R5 strobe low", rd0, 8'h00);
      cyc(1'b0, 2'b00, 1'b1, 8'hFF); chk("R8 write ones reads zero", rd0, 8'h00);
   endtask

   task automatic t_sticky;
      cyc(1'b1, 2'b01, 1'b0, 8'h00);
      cyc(1'b1, 2'b10, 1'b0, 8'h00);
      cyc(1'b1, 2'b11, 1'b0, 8'h00); chk("R6 accumulate", rd0, 8'h07);
      chk("R10 accumulate no parity", rd1, 8'h05);
      cyc(1'b0, 2'b00, 1'b1, 8'hF7); chk("R7 zero clear bit no effect", rd0, 8'h07);
      cyc(1'b1, 2'b00, 1'b0, 8'h00); chk("R6 hold", rd0, 8'h07);
      chk("R8 upper zero", rd0 & 8'hF8, 8'h00);
      cyc(1'b0, 2'b00, 1'b1, 8'h08); chk("R7 clear all", rd0, 8'h00);
      chk("R7 clear all u1", rd1, 8'h00);
   endtask

   task automatic t_collide;
      for (int c = 1; c < 4; c++) begin
         cyc(1'b1, 2'b01, 1'b0, 8'h00);
         cyc(1'b1, 2'b11, 1'b0, 8'h00);
         cyc(1'b1, 2'(c), 1'b1, 8'h08);
         chk($sformatf("R9 collide code %0d", c), rd0, 8'(1 << (c - 1)));
         chk($sformatf("R10 collide code %0d u1", c), rd1, (c == 2) ? 8'h00 : 8'(1 << (c - 1)));
         cyc(1'b0, 2'b00, 1'b1, 8'h08);
      end
   endtask

   initial begin
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_causes;
      t_ignored;
      t_sticky;
      t_collide;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule